// File: doc/BRIEF.md
# Line Error Counter with Readout Buffer

This block counts transmission errors on a telecom line and offers the count to software through a byte-wide read port. It has a 16-bit live counter and a 16-bit readable buffer. Each single-cycle error strobe adds one to the live counter. The counter stops at its maximum value and never wraps. When alarm simulation is enabled, the counter also advances once for every four received bit periods, so software can test its alarm handling without a real faulty line.

The buffer is handled in one of two ways, chosen by a mode input. In manual mode the buffer follows the live counter. Software writes a 1 to the freeze command bit, which copies the count into the buffer, holds the buffer there and restarts the live counter. Software then reads the low byte and then the high byte. Reading the high byte drops the freeze bit again. In automatic mode every once-per-second tick copies the live counter into the buffer and restarts the counter. The copied value stays readable until the next tick. The tick is also driven back out, one cycle later, as a status strobe.

Top module: `line_err_counter`

## Requirements
- R1: After reset the buffer reads 0 in both bytes, the freeze bit is 0, the second strobe output is 0, and the live counter is 0.
- R2: Each cycle with `err_evt` high adds one to the live counter. `rd_data` shows buffer bits 7:0 when `rd_hi` is 0 and bits 15:8 when `rd_hi` is 1.
- R3: The live counter holds at 0xFFFF instead of wrapping when more increments arrive.
- R4: While `alarm_sim` is high, every fourth `bit_tick` pulse adds one to the counter. The count of pulses starts again from zero whenever `alarm_sim` is low. An error strobe and an alarm increment in the same cycle add only one.
- R5: In manual mode (`auto_mode` = 0), when the freeze bit is 0, the buffer takes the live counter value at every clock edge.
- R6: In manual mode, a write of 1 to the freeze bit while it is 0 copies the live counter into the buffer and clears the live counter. The buffer then holds its value for as long as the freeze bit stays 1. A command write always loads the freeze bit with `cmd_freeze`.
- R7: A read with `rd_en` = 1 and `rd_hi` = 1, with no command write in the same cycle, clears the freeze bit. A read with `rd_hi` = 0 changes neither the freeze bit nor the buffer.
- R8: In automatic mode, a `sec_tick_i` pulse copies the live counter into the buffer and clears the counter. Between pulses the buffer holds its value, and the freeze bit has no effect on the counter or the buffer.
- R9: If an increment falls in the same cycle as a clear (the freeze rising edge, or the tick in automatic mode), the live counter starts again at 1.
- R10: `sec_tick_o` repeats `sec_tick_i` one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_evt | input | 1 | One-cycle line error strobe |
| bit_tick | input | 1 | One pulse per received bit period |
| alarm_sim | input | 1 | Alarm simulation enable |
| auto_mode | input | 1 | 1: latch on each second tick; 0: manual freeze handshake |
| sec_tick_i | input | 1 | One-cycle once-per-second tick |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_freeze | input | 1 | Freeze bit value carried by the write |
| rd_en | input | 1 | Register read strobe |
| rd_hi | input | 1 | Byte select: 1 high byte, 0 low byte |
| rd_data | output | 8 | Selected buffer byte |
| freeze_o | output | 1 | Current freeze bit |
| sec_tick_o | output | 1 | Second tick strobe, delayed one cycle |

## Verification
Two pairs of events can land in the same cycle. An increment can meet a clear, either the freeze rising edge or the automatic second tick. An error strobe can also meet an alarm-simulation increment. A directed case puts an error strobe on the same cycle as the freeze write and then expects the buffer to settle at 1. Random traffic sets these inputs independently every cycle, so both pairs come up many times. A bench model checks the buffer, the freeze bit and the strobe after every clock edge.

// File: rtl/line_err_counter.sv
module line_err_counter #(
  parameter int ALARM_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_evt,
  input  logic       bit_tick,
  input  logic       alarm_sim,
  input  logic       auto_mode,
  input  logic       sec_tick_i,
  input  logic       cmd_wr,
  input  logic       cmd_freeze,
  input  logic       rd_en,
  input  logic       rd_hi,
  output logic [7:0] rd_data,
  output logic       freeze_o,
  output logic       sec_tick_o
);
  localparam int W  = 16;
  localparam int PW = (ALARM_DIV > 2) ? $clog2(ALARM_DIV) : 1;

  logic [PW-1:0] phase;
  logic [W-1:0]  cnt, snap;
  logic          frz_q;

  wire alarm_inc = alarm_sim && bit_tick && (phase == PW'(ALARM_DIV - 1));
  wire inc       = err_evt || alarm_inc;
  wire frz_rise  = !auto_mode && cmd_wr && cmd_freeze && !frz_q;
  wire clr       = frz_rise || (auto_mode && sec_tick_i);
  wire sat       = &cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                phase <= '0;
    else if (!alarm_sim)       phase <= '0;
    else if (bit_tick)         phase <= (phase == PW'(ALARM_DIV - 1)) ? '0 : phase + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= W'(inc);
    else if (inc && !sat)      cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                frz_q <= 1'b0;
    else if (cmd_wr)           frz_q <= cmd_freeze;
    else if (rd_en && rd_hi)   frz_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                snap <= '0;
    else if (auto_mode) begin
      if (sec_tick_i)          snap <= cnt;
    end
    else if (!frz_q)           snap <= cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                sec_tick_o <= 1'b0;
    else                       sec_tick_o <= sec_tick_i;

  assign rd_data  = rd_hi ? snap[15:8] : snap[7:0];
  assign freeze_o = frz_q;
endmodule

// File: rtl/line_err_counter_chk.sv
module line_err_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        err_evt,
  input logic        auto_mode,
  input logic        sec_tick_i,
  input logic        sec_tick_o,
  input logic        cmd_wr,
  input logic        rd_en,
  input logic        rd_hi,
  input logic        clr,
  input logic        frz_q,
  input logic [15:0] cnt,
  input logic [15:0] snap
);
  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !clr && cnt != 16'hFFFF) |=> cnt == $past(cnt) + 16'd1);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'hFFFF && !clr) |=> cnt == 16'hFFFF);

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && frz_q) |=> $stable(snap));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_hi && !cmd_wr) |=> !frz_q);

  assert_auto_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !sec_tick_i) |=> $stable(snap));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && err_evt) |=> cnt == 16'd1);

  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick_i |=> sec_tick_o);
endmodule

bind line_err_counter line_err_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .auto_mode(auto_mode),
  .sec_tick_i(sec_tick_i), .sec_tick_o(sec_tick_o), .cmd_wr(cmd_wr),
  .rd_en(rd_en), .rd_hi(rd_hi), .clr(clr), .frz_q(frz_q), .cnt(cnt), .snap(snap)
);

// File: tb/sim_line_err_counter.sv
`timescale 1ns/1ps
module sim_line_err_counter;
  logic clk = 0, rst_n = 0;
  logic err_evt = 0, bit_tick = 0, alarm_sim = 0, auto_mode = 0, sec_tick_i = 0;
  logic cmd_wr = 0, cmd_freeze = 0, rd_en = 0, rd_hi = 0;
  logic [7:0] rd_data;
  logic freeze_o, sec_tick_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  line_err_counter u0 (.*);

  // reference model, built from the requirements
  logic [15:0] m_cnt, m_snap;
  logic [1:0]  m_ph;
  logic        m_frz, m_sec;

  function automatic logic alarm_step(input logic sim, input logic bt, input logic [1:0] ph);
    return sim && bt && ph == 2'd3;
  endfunction

  function automatic logic [15:0] cnt_next(input logic [15:0] c, input logic inc, input logic clr);
    if (clr) return {15'd0, inc};
    if (inc && c != 16'hFFFF) return c + 16'd1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_snap <= 0; m_ph <= 0; m_frz <= 0; m_sec <= 0;
    end else begin
      logic inc, clr;
      inc = err_evt || alarm_step(alarm_sim, bit_tick, m_ph);
      clr = (!auto_mode && cmd_wr && cmd_freeze && !m_frz) || (auto_mode && sec_tick_i);
      m_cnt <= cnt_next(m_cnt, inc, clr);
      m_ph  <= !alarm_sim ? 2'd0 : (bit_tick ? m_ph + 2'd1 : m_ph);
      if (cmd_wr) m_frz <= cmd_freeze;
      else if (rd_en && rd_hi) m_frz <= 0;
      if (auto_mode ? sec_tick_i : !m_frz) m_snap <= m_cnt;
      m_sec <= sec_tick_i;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(output logic [15:0] v);
    logic save;
    save = rd_hi;
    rd_hi = 0; #1 v[7:0] = rd_data;
    rd_hi = 1; #1 v[15:8] = rd_data;
    rd_hi = save; #1;
  endtask

  task automatic compare();
    logic [15:0] v;
    peek(v);
    chk(v == m_snap, "R2/R5/R6/R8 buffer", v, m_snap);
    chk(freeze_o == m_frz, "R6/R7 freeze bit", freeze_o, m_frz);
    chk(sec_tick_o == m_sec, "R10 strobe", sec_tick_o, m_sec);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    err_evt = 0; bit_tick = 0; sec_tick_i = 0; cmd_wr = 0; rd_en = 0;
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    peek(v);
    chk(v == 16'h0 && !freeze_o && !sec_tick_o, "R1 reset", v, 0);
    rst_n = 1;
    step();

    // R2: five errors in manual mode
    err_evt = 1; repeat (5) step(); idle(); step(); step();
    peek(v); chk(v == 16'd5, "R2 count five", v, 5);

    // R9: error on the same cycle as the freeze rising edge
    cmd_wr = 1; cmd_freeze = 1; err_evt = 1; step(); idle();
    peek(v); chk(v == 16'd5 && freeze_o, "R6 frozen capture", v, 5);
    rd_en = 1; rd_hi = 0; step(); idle();
    chk(freeze_o == 1, "R7 low read keeps freeze", freeze_o, 1);
    rd_en = 1; rd_hi = 1; step(); idle(); rd_hi = 0;
    step(); step();
    peek(v); chk(v == 16'd1, "R9 restart at one", v, 1);

    // R4: alarm simulation, 40 bit periods after a clear
    cmd_wr = 1; cmd_freeze = 1; step(); idle();
    rd_en = 1; rd_hi = 1; step(); idle(); rd_hi = 0;
    alarm_sim = 1; bit_tick = 1; repeat (40) step();
    alarm_sim = 0; idle(); step(); step();
    peek(v); chk(v == 16'd10, "R4 alarm rate", v, 10);

    // R3/R8: saturation in automatic mode
    auto_mode = 1; sec_tick_i = 1; step(); idle();
    err_evt = 1; repeat (65545) step(); idle();
    sec_tick_i = 1; step(); idle(); step();
    peek(v); chk(v == 16'hFFFF, "R3 saturate", v, 16'hFFFF);
    cmd_wr = 1; cmd_freeze = 1; err_evt = 1; step(); idle(); step();
    peek(v); chk(v == 16'hFFFF, "R8 freeze ignored in auto", v, 16'hFFFF);
    cmd_wr = 1; cmd_freeze = 0; step(); idle();

    // random traffic
    for (int i = 0; i < 30000; i++) begin
      if (i % 700 == 0) auto_mode = $urandom_range(0, 1);
      if (i % 300 == 0) alarm_sim = $urandom_range(0, 1);
      err_evt    = ($urandom_range(0, 2) == 0);
      bit_tick   = ($urandom_range(0, 1) == 0);
      sec_tick_i = ($urandom_range(0, 40) == 0);
      cmd_wr     = ($urandom_range(0, 30) == 0);
      cmd_freeze = ($urandom_range(0, 3) != 0);
      rd_en      = ($urandom_range(0, 6) == 0);
      rd_hi      = $urandom_range(0, 1);
      step();
    end
    idle(); step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4ms;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule